// File: doc/BRIEF.md
# Sequential-Consistency Violation Detection Queue

This block is a per-core tracking queue for the core's own loads and stores that could still take part in a memory-ordering cycle across threads. Each entry keeps three things for one local access: its address, its 16-bit sequence number, and two bounds for every processor in the system. The entry holds no data. The first bound is the lowest remote sequence number that may still act as a source into this access. The second is the highest remote sequence number that this access has already fed as a producer. The core allocates an entry when it issues an access. It frees entries in allocation order once they have become safe.

Two event streams move the bounds. When a remote coherence request hits a local entry, this core acts as the producer. It rejects the request if the remote sequence number is not above the entry's destination bound for that processor. Otherwise it raises that bound, as a running maximum, on the hit entry and on every younger entry. In both cases it returns the local sequence number. When a response from a remote producer arrives for a local entry, this core acts as the consumer. It rejects the response if the remote sequence number is not below the entry's source bound for that processor. Otherwise it lowers that bound, as a running minimum, on that entry and on every older entry. A rejection means a cross-thread dependence cycle is about to close. The block then raises a one-cycle exception that names the entry and the remote processor. Read-after-write, write-after-read and write-after-write dependences all go through the same check.

The entry count must be a power of two. Slot indices wrap around the ring, and age is measured from the oldest valid slot.

Top module: `dep_order_queue`

## Requirements
- R1: An accepted allocation (`alloc_valid` high while `alloc_ready` is high) writes the next ring slot and reports that slot on `alloc_idx` in the same cycle. Slots are handed out in increasing order and wrap modulo DEPTH. `alloc_ready` is low exactly when all DEPTH entries are valid, and an allocation offered while it is low is ignored.
- R2: A newly allocated entry starts with every source bound at all-ones and every destination bound at zero. From that state, a lookup with a nonzero sequence number and a response with a sequence number below all-ones raise no exception.
- R3: A lookup compares `lk_addr` against every valid entry in the same cycle. `lk_hit` is high when any valid entry matches. `lk_idx` gives the youngest matching slot, and `lk_local_seq` gives that entry's stored sequence number.
- R4: A lookup hit from processor P with sequence S raises a producer exception when S is less than or equal to the hit entry's destination bound for P.
- R5: A lookup hit that raises no exception sets the destination bound for P to max(bound, S) on the hit entry and on every younger valid entry. Older entries keep their bounds.
- R6: A response for a valid slot from producer P with sequence S raises a consumer exception when S is greater than or equal to that slot's source bound for P.
- R7: A response that raises no exception sets the source bound for P to min(bound, S) on that slot and on every older valid entry. Younger entries keep their bounds.
- R8: A retire request frees the oldest valid entry. A freed entry no longer matches lookups, and a retire request on an empty queue has no effect.
- R9: An exception shows as `exc_valid` high for exactly the one cycle after the offending event. `exc_idx` gives the slot, `exc_proc` gives the remote processor, and `exc_side` is 0 for producer and 1 for consumer. When both sides fail in the same cycle, the producer exception is reported.
- R10: A response that names a slot which is not valid is ignored. It neither raises an exception nor changes any bound.
- R11: A lookup that matches no valid entry changes no bound and raises no exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Core offers a new access |
| alloc_addr | input | ADDR_W | Address of the new access |
| alloc_seq | input | SEQ_W | Sequence number of the new access |
| alloc_ready | output | 1 | Queue has a free slot |
| alloc_idx | output | log2(DEPTH) | Slot assigned to the offered access |
| lk_valid | input | 1 | Incoming remote coherence request |
| lk_addr | input | ADDR_W | Address of the remote request |
| lk_proc | input | log2(NPROC) | Requesting processor |
| lk_seq | input | SEQ_W | Requester's sequence number |
| lk_hit | output | 1 | A valid local entry matches |
| lk_idx | output | log2(DEPTH) | Youngest matching slot |
| lk_local_seq | output | SEQ_W | Sequence number returned to the requester |
| rsp_valid | input | 1 | Response from a remote producer arrives |
| rsp_idx | input | log2(DEPTH) | Local slot the response belongs to |
| rsp_proc | input | log2(NPROC) | Producing processor |
| rsp_seq | input | SEQ_W | Producer's sequence number |
| ret_valid | input | 1 | Free the oldest entry |
| exc_valid | output | 1 | One-cycle exception pulse |
| exc_idx | output | log2(DEPTH) | Slot that caused the exception |
| exc_proc | output | log2(NPROC) | Remote processor involved |
| exc_side | output | 1 | 0 for producer, 1 for consumer |

## Verification
Some behaviours hold in every cycle, and the in-line assertions check those. The occupancy count follows accepted allocations and retirements. Allocation never lands on a live slot, and retirement always frees a live one. A hit always points at a valid entry. Any exception pulse is preceded by a failed check. After every accepted update, each entry in the spread range holds a bound at least as tight as the incoming number. Other behaviours appear only when the bench's scenarios and its reference model are compared. These are: which matching entry wins, the exact boundary at equality, the absence of spread toward the wrong age, the priority between the two sides, the ignoring of stale slots, and full-queue backpressure.

// File: rtl/ordq_pkg.sv
package ordq_pkg;
  typedef enum logic {
    EXC_PRODUCER = 1'b0,
    EXC_CONSUMER = 1'b1
  } exc_side_e;
endpackage

// File: rtl/ordq_ring.sv
// Ring-pointer occupancy tracker: head is the oldest live slot, tail the next free one.
module ordq_ring #(
  parameter int DEPTH = 256
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     alloc_req,
  input  logic                     ret_req,
  output logic                     alloc_fire,
  output logic                     ret_fire,
  output logic [$clog2(DEPTH)-1:0] head,
  output logic [$clog2(DEPTH)-1:0] tail,
  output logic [DEPTH-1:0]         valid,
  output logic                     full
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = IDX_W + 1;

  logic [CNT_W-1:0] count;

  assign full       = (count == CNT_W'(DEPTH));
  assign alloc_fire = alloc_req && !full;
  assign ret_fire   = ret_req && (count != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
      valid <= '0;
    end else begin
      if (alloc_fire) begin
        valid[tail] <= 1'b1;
        tail        <= tail + 1'b1;
      end
      if (ret_fire) begin
        valid[head] <= 1'b0;
        head        <= head + 1'b1;
      end
      count <= count + CNT_W'(alloc_fire) - CNT_W'(ret_fire);
    end
  end

  assert_alloc_grows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_fire && !ret_fire) |=> (count == $past(count) + 1'b1));

  assert_tail_free_R1: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire |-> !valid[tail]);

  assert_retire_shrinks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_fire && !alloc_fire) |=> (count == $past(count) - 1'b1));

  assert_head_live_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ret_fire |-> valid[head]);
endmodule

// File: rtl/ordq_match.sv
// Associative address search; the scan walks from oldest to youngest so the last match wins.
module ordq_match #(
  parameter int DEPTH  = 256,
  parameter int ADDR_W = 32,
  parameter int SEQ_W  = 16
) (
  input  logic [DEPTH-1:0]              valid,
  input  logic [$clog2(DEPTH)-1:0]      head,
  input  logic [DEPTH-1:0][ADDR_W-1:0]  addr_tab,
  input  logic [DEPTH-1:0][SEQ_W-1:0]   seq_tab,
  input  logic                          lk_valid,
  input  logic [ADDR_W-1:0]             lk_addr,
  output logic                          hit,
  output logic [$clog2(DEPTH)-1:0]      hit_idx,
  output logic [SEQ_W-1:0]              hit_seq
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [IDX_W-1:0] slot;

  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    slot    = '0;
    for (int k = 0; k < DEPTH; k++) begin
      slot = head + IDX_W'(k);
      if (lk_valid && valid[slot] && (addr_tab[slot] == lk_addr)) begin
        hit     = 1'b1;
        hit_idx = slot;
      end
    end
  end

  assign hit_seq = seq_tab[hit_idx];
endmodule

// File: rtl/ordq_bounds.sv
// Per-entry, per-processor source/destination bounds with the range checks and the age-ordered spread.
module ordq_bounds #(
  parameter int DEPTH = 256,
  parameter int NPROC = 8,
  parameter int SEQ_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [DEPTH-1:0]         valid,
  input  logic [$clog2(DEPTH)-1:0] head,
  input  logic                     alloc_fire,
  input  logic [$clog2(DEPTH)-1:0] alloc_slot,
  input  logic                     lk_hit,
  input  logic [$clog2(DEPTH)-1:0] lk_idx,
  input  logic [$clog2(NPROC)-1:0] lk_proc,
  input  logic [SEQ_W-1:0]         lk_seq,
  input  logic                     rsp_valid,
  input  logic [$clog2(DEPTH)-1:0] rsp_idx,
  input  logic [$clog2(NPROC)-1:0] rsp_proc,
  input  logic [SEQ_W-1:0]         rsp_seq,
  output logic                     prod_exc_ev,
  output logic                     cons_exc_ev
);
  localparam int IDX_W = $clog2(DEPTH);

  function automatic logic [SEQ_W-1:0] seq_max(logic [SEQ_W-1:0] a, logic [SEQ_W-1:0] b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic [SEQ_W-1:0] seq_min(logic [SEQ_W-1:0] a, logic [SEQ_W-1:0] b);
    return (a < b) ? a : b;
  endfunction

  // Distance from the oldest live slot; larger means younger.
  function automatic logic [IDX_W-1:0] age_of(logic [IDX_W-1:0] slot, logic [IDX_W-1:0] base);
    return slot - base;
  endfunction

  logic [DEPTH-1:0][NPROC-1:0][SEQ_W-1:0] src_all;
  logic [DEPTH-1:0][NPROC-1:0][SEQ_W-1:0] dst_all;
  logic [DEPTH-1:0] prod_mask;
  logic [DEPTH-1:0] cons_mask;
  logic             rsp_live;
  logic             prod_upd_ev;
  logic             cons_upd_ev;
  logic [SEQ_W-1:0] dst_at_hit;
  logic [SEQ_W-1:0] src_at_rsp;

  assign dst_at_hit  = dst_all[lk_idx][lk_proc];
  assign src_at_rsp  = src_all[rsp_idx][rsp_proc];
  assign rsp_live    = rsp_valid && valid[rsp_idx];
  assign prod_exc_ev = lk_hit && (lk_seq <= dst_at_hit);
  assign cons_exc_ev = rsp_live && (rsp_seq >= src_at_rsp);
  assign prod_upd_ev = lk_hit && !prod_exc_ev;
  assign cons_upd_ev = rsp_live && !cons_exc_ev;

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    logic [NPROC-1:0][SEQ_W-1:0] src_q;
    logic [NPROC-1:0][SEQ_W-1:0] dst_q;

    assign prod_mask[e] = valid[e] && (age_of(IDX_W'(e), head) >= age_of(lk_idx, head));
    assign cons_mask[e] = valid[e] && (age_of(IDX_W'(e), head) <= age_of(rsp_idx, head));
    assign src_all[e]   = src_q;
    assign dst_all[e]   = dst_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        src_q <= '1;
        dst_q <= '0;
      end else if (alloc_fire && (alloc_slot == IDX_W'(e))) begin
        src_q <= '1;
        dst_q <= '0;
      end else begin
        if (prod_upd_ev && prod_mask[e])
          dst_q[lk_proc] <= seq_max(dst_q[lk_proc], lk_seq);
        if (cons_upd_ev && cons_mask[e])
          src_q[rsp_proc] <= seq_min(src_q[rsp_proc], rsp_seq);
      end
    end

    assert_dst_raised_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (prod_upd_ev && prod_mask[e]) |=> (dst_q[$past(lk_proc)] >= $past(lk_seq)));

    assert_src_lowered_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cons_upd_ev && cons_mask[e]) |=> (src_q[$past(rsp_proc)] <= $past(rsp_seq)));
  end
endmodule

// File: rtl/dep_order_queue.sv
module dep_order_queue
  import ordq_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int NPROC  = 8,
  parameter int ADDR_W = 32,
  parameter int SEQ_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     alloc_valid,
  input  logic [ADDR_W-1:0]        alloc_addr,
  input  logic [SEQ_W-1:0]         alloc_seq,
  output logic                     alloc_ready,
  output logic [$clog2(DEPTH)-1:0] alloc_idx,
  input  logic                     lk_valid,
  input  logic [ADDR_W-1:0]        lk_addr,
  input  logic [$clog2(NPROC)-1:0] lk_proc,
  input  logic [SEQ_W-1:0]         lk_seq,
  output logic                     lk_hit,
  output logic [$clog2(DEPTH)-1:0] lk_idx,
  output logic [SEQ_W-1:0]         lk_local_seq,
  input  logic                     rsp_valid,
  input  logic [$clog2(DEPTH)-1:0] rsp_idx,
  input  logic [$clog2(NPROC)-1:0] rsp_proc,
  input  logic [SEQ_W-1:0]         rsp_seq,
  input  logic                     ret_valid,
  output logic                     exc_valid,
  output logic [$clog2(DEPTH)-1:0] exc_idx,
  output logic [$clog2(NPROC)-1:0] exc_proc,
  output logic                     exc_side
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int PID_W = $clog2(NPROC);

  logic                             alloc_fire;
  logic                             ret_fire;
  logic [IDX_W-1:0]                 head;
  logic [IDX_W-1:0]                 tail;
  logic [DEPTH-1:0]                 valid;
  logic                             full;
  logic [DEPTH-1:0][ADDR_W-1:0]     addr_tab;
  logic [DEPTH-1:0][SEQ_W-1:0]      seq_tab;
  logic                             prod_exc_ev;
  logic                             cons_exc_ev;

  ordq_ring #(.DEPTH(DEPTH)) ring_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc_req  (alloc_valid),
    .ret_req    (ret_valid),
    .alloc_fire (alloc_fire),
    .ret_fire   (ret_fire),
    .head       (head),
    .tail       (tail),
    .valid      (valid),
    .full       (full)
  );

  assign alloc_ready = !full;
  assign alloc_idx   = tail;

  always_ff @(posedge clk) begin
    if (alloc_fire) begin
      addr_tab[tail] <= alloc_addr;
      seq_tab[tail]  <= alloc_seq;
    end
  end

  ordq_match #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .SEQ_W(SEQ_W)) match_i (
    .valid    (valid),
    .head     (head),
    .addr_tab (addr_tab),
    .seq_tab  (seq_tab),
    .lk_valid (lk_valid),
    .lk_addr  (lk_addr),
    .hit      (lk_hit),
    .hit_idx  (lk_idx),
    .hit_seq  (lk_local_seq)
  );

  ordq_bounds #(.DEPTH(DEPTH), .NPROC(NPROC), .SEQ_W(SEQ_W)) bounds_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .valid       (valid),
    .head        (head),
    .alloc_fire  (alloc_fire),
    .alloc_slot  (tail),
    .lk_hit      (lk_hit),
    .lk_idx      (lk_idx),
    .lk_proc     (lk_proc),
    .lk_seq      (lk_seq),
    .rsp_valid   (rsp_valid),
    .rsp_idx     (rsp_idx),
    .rsp_proc    (rsp_proc),
    .rsp_seq     (rsp_seq),
    .prod_exc_ev (prod_exc_ev),
    .cons_exc_ev (cons_exc_ev)
  );

  // Producer failures take priority when both sides fail together.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exc_valid <= 1'b0;
      exc_idx   <= '0;
      exc_proc  <= '0;
      exc_side  <= EXC_PRODUCER;
    end else begin
      exc_valid <= prod_exc_ev || cons_exc_ev;
      if (prod_exc_ev) begin
        exc_idx  <= lk_idx;
        exc_proc <= lk_proc;
        exc_side <= EXC_PRODUCER;
      end else if (cons_exc_ev) begin
        exc_idx  <= rsp_idx;
        exc_proc <= PID_W'(rsp_proc);
        exc_side <= EXC_CONSUMER;
      end
    end
  end

  assert_hit_live_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_valid && valid[lk_idx]));

  assert_exc_has_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> $past(prod_exc_ev || cons_exc_ev));

  assert_producer_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (prod_exc_ev && cons_exc_ev) |=> (exc_valid && (exc_side == EXC_PRODUCER) && (exc_idx == $past(lk_idx))));

  assert_stale_rsp_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !valid[rsp_idx]) |-> !cons_exc_ev);

  assert_miss_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> !prod_exc_ev);
endmodule

// File: tb/dep_order_queue_tb_top.sv
`timescale 1ns/1ps
module dep_order_queue_tb_top;
  localparam int DEPTH = 256;
  localparam int NPROC = 8;
  localparam int AW    = 32;
  localparam int SW    = 16;
  localparam int IW    = 8;
  localparam int PW    = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n;
  logic          a_v, l_v, r_v, t_v;
  logic [AW-1:0] a_addr, l_addr;
  logic [SW-1:0] a_seq, l_seq, r_seq;
  logic [PW-1:0] l_proc, r_proc;
  logic [IW-1:0] r_idx;

  logic          alloc_ready, lk_hit, exc_valid, exc_side;
  logic [IW-1:0] alloc_idx, lk_idx, exc_idx;
  logic [SW-1:0] lk_local_seq;
  logic [PW-1:0] exc_proc;

  dep_order_queue dut_i (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(a_v), .alloc_addr(a_addr), .alloc_seq(a_seq),
    .alloc_ready(alloc_ready), .alloc_idx(alloc_idx),
    .lk_valid(l_v), .lk_addr(l_addr), .lk_proc(l_proc), .lk_seq(l_seq),
    .lk_hit(lk_hit), .lk_idx(lk_idx), .lk_local_seq(lk_local_seq),
    .rsp_valid(r_v), .rsp_idx(r_idx), .rsp_proc(r_proc), .rsp_seq(r_seq),
    .ret_valid(t_v),
    .exc_valid(exc_valid), .exc_idx(exc_idx), .exc_proc(exc_proc), .exc_side(exc_side)
  );

  typedef struct packed {
    logic [IW-1:0]              slot;
    logic [AW-1:0]              addr;
    logic [SW-1:0]              seq;
    logic [NPROC-1:0][SW-1:0]   src_b;
    logic [NPROC-1:0][SW-1:0]   dst_b;
  } ent_t;

  ent_t mq[$];
  int   tail_m;
  int   checks;
  int   errors;
  bit   pe_v;
  int   pe_idx, pe_proc, pe_side;

  task automatic chkv(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clear_inputs();
    a_v = 0; l_v = 0; r_v = 0; t_v = 0;
    a_addr = '0; l_addr = '0; a_seq = '0; l_seq = '0; r_seq = '0;
    l_proc = '0; r_proc = '0; r_idx = '0;
  endtask

  // Called at a falling edge with inputs already set; compares, predicts, advances one cycle.
  task automatic step();
    int   hp, rp;
    bit   pexc, cexc, full_pre;
    ent_t e;
    #1;
    chkv("R1 alloc_ready", alloc_ready, mq.size() < DEPTH);
    if (a_v && mq.size() < DEPTH) chkv("R1 alloc_idx", alloc_idx, tail_m);
    hp = -1;
    if (l_v) foreach (mq[i]) if (mq[i].addr == l_addr) hp = i;
    chkv("R3 lk_hit", lk_hit, hp >= 0);
    if (hp >= 0) begin
      chkv("R3 lk_idx", lk_idx, mq[hp].slot);
      chkv("R3 lk_local_seq", lk_local_seq, mq[hp].seq);
    end
    chkv("R9 exc_valid", exc_valid, pe_v);
    if (pe_v) begin
      chkv("R9 exc_idx", exc_idx, pe_idx);
      chkv("R9 exc_proc", exc_proc, pe_proc);
      chkv("R9 exc_side", exc_side, pe_side);
    end
    rp = -1;
    if (r_v) foreach (mq[i]) if (mq[i].slot == r_idx) rp = i;
    pexc = (hp >= 0) && (l_seq <= mq[hp].dst_b[l_proc]);
    cexc = (rp >= 0) && (r_seq >= mq[rp].src_b[r_proc]);
    pe_v = pexc || cexc;
    if (pexc) begin
      pe_idx = mq[hp].slot; pe_proc = l_proc; pe_side = 0;
    end else if (cexc) begin
      pe_idx = mq[rp].slot; pe_proc = r_proc; pe_side = 1;
    end
    if (hp >= 0 && !pexc)
      for (int i = hp; i < mq.size(); i++)
        if (mq[i].dst_b[l_proc] < l_seq) mq[i].dst_b[l_proc] = l_seq;
    if (rp >= 0 && !cexc)
      for (int i = 0; i <= rp; i++)
        if (mq[i].src_b[r_proc] > r_seq) mq[i].src_b[r_proc] = r_seq;
    full_pre = (mq.size() >= DEPTH);
    if (t_v && mq.size() > 0) void'(mq.pop_front());
    if (a_v && !full_pre) begin
      e.slot = IW'(tail_m); e.addr = a_addr; e.seq = a_seq;
      e.src_b = '1; e.dst_b = '0;
      mq.push_back(e);
      tail_m = (tail_m + 1) % DEPTH;
    end
    @(posedge clk);
    @(negedge clk);
    clear_inputs();
  endtask

  task automatic do_alloc(logic [AW-1:0] ad, logic [SW-1:0] sq);
    a_v = 1; a_addr = ad; a_seq = sq; step();
  endtask
  task automatic do_lk(logic [AW-1:0] ad, int p, logic [SW-1:0] sq);
    l_v = 1; l_addr = ad; l_proc = PW'(p); l_seq = sq; step();
  endtask
  task automatic do_rsp(int idx, int p, logic [SW-1:0] sq);
    r_v = 1; r_idx = IW'(idx); r_proc = PW'(p); r_seq = sq; step();
  endtask
  task automatic do_ret();
    t_v = 1; step();
  endtask

  initial begin
    #(8ns * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    checks = 0; errors = 0; tail_m = 0; pe_v = 0;
    clear_inputs();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    step();                                   // reset state: ready, no hit, no exception (R1, R3, R9)

    // R1 / R3: five entries, slot 4 duplicates the address of slot 1
    do_alloc(32'h100, 1);
    do_alloc(32'h104, 2);
    do_alloc(32'h108, 3);
    do_alloc(32'h10C, 4);
    do_alloc(32'h104, 5);
    do_lk(32'h104, 1, 30);                    // R3 youngest match is slot 4
    do_lk(32'h100, 2, 50);                    // R2 fresh bounds accept; R5 spread to slots 0..4
    do_lk(32'h108, 2, 50);                    // R4 equality rejects
    step();                                   // R9 pulse lasts one cycle
    do_lk(32'h108, 2, 51);                    // R5 raise slots 2..4
    do_lk(32'h100, 2, 51);                    // R5 older slot 0 stayed at 50, accepted
    do_lk(32'h100, 3, 1);                     // R2 other processor untouched
    do_rsp(3, 5, 40);                         // R7 lower slots 0..3
    do_rsp(1, 5, 40);                         // R6 equality rejects
    do_rsp(4, 5, 60);                         // R7 younger slot 4 untouched, accepted
    do_rsp(2, 5, 39);                         // R7 lower slots 0..2
    do_rsp(0, 5, 39);                         // R6 rejects
    do_rsp(0, 6, 16'hFFFE);                   // R2 fresh source bound accepts
    l_v = 1; l_addr = 32'h100; l_proc = 2; l_seq = 10;
    r_v = 1; r_idx = 1; r_proc = 5; r_seq = 39;
    step();                                   // R9 both fail, producer reported
    do_rsp(200, 5, 0);                        // R10 stale slot ignored
    do_rsp(4, 5, 61);                         // R10 slot 4 bound still 60 -> rejects
    do_lk(32'h999, 2, 1);                     // R11 miss
    do_lk(32'h10C, 2, 52);                    // R11 bounds after miss unchanged, accepted
    do_ret();
    do_ret();                                 // R8 slots 0 and 1 freed
    do_lk(32'h100, 2, 100);                   // R8 retired address misses
    step();

    // R1 fill to capacity, offer when full, retire+alloc at full
    for (int i = 0; i < DEPTH; i++) do_alloc(32'h1000 + i, SW'(i + 10));
    do_alloc(32'h5555, 7);                    // R1 ignored while full
    a_v = 1; a_addr = 32'h6666; a_seq = 8; t_v = 1;
    step();
    for (int i = 0; i < DEPTH + 4; i++) do_ret(); // R8 drain past empty
    do_lk(32'h6666, 0, 1);                    // R1 offer at full was dropped

    // mixed random traffic, compared every cycle
    for (int c = 0; c < 3000; c++) begin
      a_v = ($urandom_range(0, 2) != 0); a_addr = 32'h40 + 4 * $urandom_range(0, 7);
      a_seq = SW'($urandom_range(1, 500));
      l_v = ($urandom_range(0, 1) != 0); l_addr = 32'h40 + 4 * $urandom_range(0, 7);
      l_proc = PW'($urandom_range(0, NPROC - 1)); l_seq = SW'($urandom_range(1, 300));
      r_v = ($urandom_range(0, 1) != 0); r_idx = IW'($urandom_range(0, DEPTH - 1));
      r_proc = PW'($urandom_range(0, NPROC - 1)); r_seq = SW'($urandom_range(0, 300));
      t_v = ($urandom_range(0, 2) == 0);
      step();
    end
    step();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule